// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block watches the two wires of an I2C bus on behalf of a slave device and keeps the status flags that the host side reads back. It spots start and stop conditions on the already synchronised clock and data samples. It records which of the two conditions came most recently. It also keeps the direction bit latched at the last address match and raises a request when a 10-bit address needs its next byte loaded. Two more flags are kept: one says whether the last received byte was an address or data, and one says whether the byte buffer is full.

Around the block sit the byte shifter, the address comparator and the clock stretching logic. They report to it through single-cycle strobes: address matched, acknowledge bit, byte received, host read the buffer, host loaded a transmit byte, transmit finished, and host wrote the address register. The block turns those strobes and the bus edges into one 8-bit status word. An enable input switches condition detection on and off.

Top module: `i2c_slv_status`

## Requirements
- R1: After reset, status_o reads 0x00.
- R2: If SDA falls while SCL is high on both the previous and the current sample, and en_i is 1, the start flag goes to 1 and the stop flag goes to 0 one clock later.
- R3: If SDA rises while SCL is high on both the previous and the current sample, and en_i is 1, the stop flag goes to 1 and the start flag goes to 0 one clock later.
- R4: The start and stop flags are never 1 together. SDA changes while SCL is low leave every flag unchanged.
- R5: While en_i is 0, the start and stop flags are 0 from the next clock on, and bus conditions do not set them.
- R6: addr_match_i captures rw_bit_i into the direction flag (1 read, 0 write). A later start, stop or ack_i strobe clears the flag to 0. A capture in the same cycle as ack_i wins.
- R7: rx_byte_i sets the data flag to 1 when rx_is_addr_i is 0, and to 0 when rx_is_addr_i is 1.
- R8: addr_match_i with ten_bit_i set raises the update-address flag. addr_wr_i clears it. A raise in the same cycle as addr_wr_i wins.
- R9: rx_byte_i sets the buffer-full flag and buf_rd_i clears it.
- R10: tx_load_i sets the buffer-full flag. The flag stays 1 on idle cycles until tx_done_i clears it.
- R11: status_o layout: bit0 start, bit1 stop, bit2 data, bit3 direction, bit4 update-address, bit5 buffer-full, bits 7:6 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enables condition detection; while 0, start and stop flags are cleared |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| addr_match_i | input | 1 | Address comparator match strobe |
| rw_bit_i | input | 1 | Direction bit of the matched address byte |
| ten_bit_i | input | 1 | 10-bit addressing mode |
| ack_i | input | 1 | Acknowledge bit strobe |
| addr_wr_i | input | 1 | Host wrote the address register |
| rx_byte_i | input | 1 | Byte received strobe |
| rx_is_addr_i | input | 1 | Received byte was an address byte |
| buf_rd_i | input | 1 | Host read the receive buffer |
| tx_load_i | input | 1 | Host loaded a transmit byte |
| tx_done_i | input | 1 | Transmit of the byte finished |
| status_o | output | 8 | Status word, layout per R11 |

## Verification
Every result shows up exactly one clock after its cause. A strobe is sampled at one rising edge and its flag is visible after that edge. A bus condition is found by comparing the new SDA sample with the one registered at the previous edge, so it also lands after the edge that first sees the new SDA level. The bench drives every input 1 ns after a rising edge and reads status_o 1 ns after the following edge. It compares the whole word against a model updated from the requirements. Strobes are dropped right after that edge, so each check sees one event in isolation. Additional checks on idle cycles confirm that flags hold their value.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned B_START   = 0;
  localparam int unsigned B_STOP    = 1;
  localparam int unsigned B_DATA    = 2;
  localparam int unsigned B_RW      = 3;
  localparam int unsigned B_UPD     = 4;
  localparam int unsigned B_BUFFULL = 5;

  typedef struct packed {
    logic bf;
    logic ua;
    logic rw;
    logic da;
    logic sp;
    logic st;
  } flags_t;

  function automatic logic [STAT_W-1:0] pack_status(flags_t f);
    logic [STAT_W-1:0] s;
    s            = '0;
    s[B_START]   = f.st;
    s[B_STOP]    = f.sp;
    s[B_DATA]    = f.da;
    s[B_RW]      = f.rw;
    s[B_UPD]     = f.ua;
    s[B_BUFFULL] = f.bf;
    return s;
  endfunction
endpackage

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  // idle bus is high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o = scl_q & scl_i & sda_q & ~sda_i;
    stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_link_flags.sv
module i2c_link_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic addr_match_i,
  input  logic rw_bit_i,
  input  logic ten_bit_i,
  input  logic ack_i,
  input  logic addr_wr_i,
  output logic st_o,
  output logic sp_o,
  output logic rw_o,
  output logic ua_o
);
  logic st_q, sp_q, rw_q, ua_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= 1'b0;
      sp_q <= 1'b0;
    end else if (!en_i) begin
      st_q <= 1'b0;
      sp_q <= 1'b0;
    end else if (start_i) begin
      st_q <= 1'b1;
      sp_q <= 1'b0;
    end else if (stop_i) begin
      st_q <= 1'b0;
      sp_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 rw_q <= 1'b0;
    else if (addr_match_i)                       rw_q <= rw_bit_i;
    else if (ack_i || start_i || stop_i)         rw_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ua_q <= 1'b0;
    else if (addr_match_i && ten_bit_i)  ua_q <= 1'b1;
    else if (addr_wr_i)                  ua_q <= 1'b0;
  end

  assign st_o = st_q;
  assign sp_o = sp_q;
  assign rw_o = rw_q;
  assign ua_o = ua_q;

  a_r4_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_q && sp_q));
  a_r2_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i) |=> (st_q && !sp_q));
  a_r3_stop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stop_i) |=> (sp_q && !st_q));
  a_r5_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!st_q && !sp_q));
  a_r6_rw_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_i |=> (rw_q == $past(rw_bit_i)));
  a_r8_upd_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_match_i && ten_bit_i) |=> ua_q);
endmodule

// File: rtl/i2c_buf_flags.sv
module i2c_buf_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_byte_i,
  input  logic rx_is_addr_i,
  input  logic buf_rd_i,
  input  logic tx_load_i,
  input  logic tx_done_i,
  output logic da_o,
  output logic bf_o
);
  logic da_q, bf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        da_q <= 1'b0;
    else if (rx_byte_i) da_q <= ~rx_is_addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       bf_q <= 1'b0;
    else if (rx_byte_i || tx_load_i)   bf_q <= 1'b1;
    else if (buf_rd_i || tx_done_i)    bf_q <= 1'b0;
  end

  assign da_o = da_q;
  assign bf_o = bf_q;

  a_r7_data_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_byte_i |=> (da_q == !$past(rx_is_addr_i)));
  a_r9_bf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_byte_i || tx_load_i) |=> bf_q);
  a_r10_bf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_byte_i && !tx_load_i && (buf_rd_i || tx_done_i)) |=> !bf_q);
endmodule

// File: rtl/i2c_slv_status.sv
module i2c_slv_status
  import i2c_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_match_i,
  input  logic              rw_bit_i,
  input  logic              ten_bit_i,
  input  logic              ack_i,
  input  logic              addr_wr_i,
  input  logic              rx_byte_i,
  input  logic              rx_is_addr_i,
  input  logic              buf_rd_i,
  input  logic              tx_load_i,
  input  logic              tx_done_i,
  output logic [STAT_W-1:0] status_o
);
  logic   start_det, stop_det;
  flags_t flags;

  i2c_cond_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_det),
    .stop_o  (stop_det)
  );

  i2c_link_flags u_link (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .start_i      (start_det),
    .stop_i       (stop_det),
    .addr_match_i (addr_match_i),
    .rw_bit_i     (rw_bit_i),
    .ten_bit_i    (ten_bit_i),
    .ack_i        (ack_i),
    .addr_wr_i    (addr_wr_i),
    .st_o         (flags.st),
    .sp_o         (flags.sp),
    .rw_o         (flags.rw),
    .ua_o         (flags.ua)
  );

  i2c_buf_flags u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_byte_i    (rx_byte_i),
    .rx_is_addr_i (rx_is_addr_i),
    .buf_rd_i     (buf_rd_i),
    .tx_load_i    (tx_load_i),
    .tx_done_i    (tx_done_i),
    .da_o         (flags.da),
    .bf_o         (flags.bf)
  );

  assign status_o = pack_status(flags);

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_match_i && !ack_i && !addr_wr_i && !rx_byte_i && !buf_rd_i &&
     !tx_load_i && !tx_done_i && !start_det && !stop_det && en_i)
    |=> $stable(status_o));
endmodule

// File: tb/i2c_slv_status_test.sv
`timescale 1ns/1ps
module i2c_slv_status_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1, scl_i = 1'b1, sda_i = 1'b1;
  logic addr_match_i = 0, rw_bit_i = 0, ten_bit_i = 0, ack_i = 0, addr_wr_i = 0;
  logic rx_byte_i = 0, rx_is_addr_i = 0, buf_rd_i = 0, tx_load_i = 0, tx_done_i = 0;
  logic [7:0] status_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_st = 0, m_sp = 0, m_da = 0, m_rw = 0, m_ua = 0, m_bf = 0;

  always #2.5 clk = ~clk;

  i2c_slv_status uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .scl_i(scl_i), .sda_i(sda_i),
    .addr_match_i(addr_match_i), .rw_bit_i(rw_bit_i), .ten_bit_i(ten_bit_i),
    .ack_i(ack_i), .addr_wr_i(addr_wr_i), .rx_byte_i(rx_byte_i),
    .rx_is_addr_i(rx_is_addr_i), .buf_rd_i(buf_rd_i), .tx_load_i(tx_load_i),
    .tx_done_i(tx_done_i), .status_o(status_o)
  );

  // R11 layout
  function automatic logic [7:0] exp_word();
    return {2'b00, m_bf, m_ua, m_rw, m_da, m_sp, m_st};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag);
    n_chk++;
    if (status_o !== exp_word()) begin
      n_bad++;
      $display("FAIL %s: status=%02h expected=%02h", tag, status_o, exp_word());
    end
  endtask

  task automatic do_start(input string tag);
    scl_i = 1'b0; tick();
    sda_i = 1'b1; tick();
    scl_i = 1'b1; tick();
    sda_i = 1'b0; tick();
    if (en_i) begin m_st = 1; m_sp = 0; end
    m_rw = 0;
    chk(tag);
  endtask

  task automatic do_stop(input string tag);
    scl_i = 1'b0; tick();
    sda_i = 1'b0; tick();
    scl_i = 1'b1; tick();
    sda_i = 1'b1; tick();
    if (en_i) begin m_st = 0; m_sp = 1; end
    m_rw = 0;
    chk(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: status=%02h expected=%02h", status_o, exp_word());
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 reset state");

    do_start("R2 start sets start clears stop");
    do_stop("R3 stop sets stop clears start");
    do_start("R2 start after stop");
    do_stop("R3 stop after start");

    // R4: SDA toggles with SCL low
    scl_i = 1'b0; tick();
    for (int i = 0; i < 4; i++) begin
      sda_i = ~sda_i; tick();
      chk("R4 sda change with scl low ignored");
    end

    // R6 / R8 sweep
    for (int r = 0; r < 2; r++) begin
      for (int t = 0; t < 2; t++) begin
        addr_wr_i = 1; tick(); addr_wr_i = 0; m_ua = 0;
        chk("R8 addr write clears update flag");
        addr_match_i = 1; rw_bit_i = r[0]; ten_bit_i = t[0]; tick();
        addr_match_i = 0; rw_bit_i = 0; ten_bit_i = 0;
        m_rw = r[0]; if (t != 0) m_ua = 1;
        chk("R6 R8 address match capture");
        tick(); chk("R6 hold on idle");
        ack_i = 1; tick(); ack_i = 0; m_rw = 0;
        chk("R6 ack clears direction");
      end
    end
    // capture wins over ack; set wins over addr write
    addr_match_i = 1; rw_bit_i = 1; ten_bit_i = 1; ack_i = 1; addr_wr_i = 1; tick();
    addr_match_i = 0; rw_bit_i = 0; ten_bit_i = 0; ack_i = 0; addr_wr_i = 0;
    m_rw = 1; m_ua = 1;
    chk("R6 R8 simultaneous priority");
    do_start("R6 start clears direction");
    addr_match_i = 1; rw_bit_i = 1; tick(); addr_match_i = 0; rw_bit_i = 0; m_rw = 1;
    chk("R6 capture read");
    do_stop("R6 stop clears direction");
    addr_wr_i = 1; tick(); addr_wr_i = 0; m_ua = 0;
    chk("R8 clear");

    // R7 / R9 receive sweep
    for (int a = 0; a < 2; a++) begin
      rx_byte_i = 1; rx_is_addr_i = a[0]; tick();
      rx_byte_i = 0; rx_is_addr_i = 0;
      m_da = (a == 0); m_bf = 1;
      chk("R7 R9 byte received");
      buf_rd_i = 1; tick(); buf_rd_i = 0; m_bf = 0;
      chk("R9 buffer read clears full");
    end

    // R10 transmit
    tx_load_i = 1; tick(); tx_load_i = 0; m_bf = 1;
    chk("R10 transmit load sets full");
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R10 full holds during transmit");
    end
    tx_done_i = 1; tick(); tx_done_i = 0; m_bf = 0;
    chk("R10 transmit done clears full");

    // R5 enable
    do_start("R2 start before disable");
    en_i = 1'b0; tick(); m_st = 0; m_sp = 0;
    chk("R5 disable clears start");
    do_stop("R5 stop ignored while disabled");
    do_start("R5 start ignored while disabled");
    en_i = 1'b1; tick();
    chk("R5 re-enable no spurious flag");
    do_stop("R3 stop after re-enable");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule